// File: doc/BRIEF.md
# Program Counter with Return-Address Stack

This block is the program-flow unit of a small 8-bit controller with a 10-bit code address space. It holds the program counter and a hardware stack of return addresses. On every enabled step it takes a decoded flow command, a condition selector, the current carry and zero flags and a 10-bit target address. From these it sets the program counter for the next instruction.

A jump, call or return can be unconditional, or it can depend on carry set, carry clear, zero set or zero clear. When the condition fails, the command falls through to the next sequential address and leaves the stack alone. A call saves the current address. A return resumes at the saved address plus one. A call on a full stack raises a sticky overflow flag, and a return on an empty stack raises a sticky underflow flag.

Top module: `pc_stack_unit`

## Requirements
- R1: While rst_ni is low, the block holds pc_o = 0x000 and tos_o = 0, with ovf_o and unf_o low.
- R2: When step_i is low, pc_o, tos_o, ovf_o and unf_o keep their values on the clock edge, whatever the other inputs are.
- R3: On a step with cmd_i = 0 (none), pc_o becomes pc_o + 1 modulo 1024, so 0x3FF is followed by 0x000.
- R4: On a step with cmd_i = 1 (jump) whose condition holds, pc_o becomes target_i. The cond_i encodings are: 0 always, 1 carry set, 2 carry clear, 3 zero set, 4 zero clear. Codes 5 to 7 never hold.
- R5: On a step whose command is jump, call or return and whose condition fails, pc_o becomes pc_o + 1, and tos_o and the stack contents are unchanged.
- R6: On a step with cmd_i = 2 (call) whose condition holds and whose stack is not full, the current pc_o is pushed, tos_o rises by one and pc_o becomes target_i.
- R7: On a step with cmd_i = 3 (return) whose condition holds and whose stack is not empty, pc_o becomes the top saved address plus one, and tos_o falls by one.
- R8: The stack holds 30 entries. A taken call while tos_o = 30 sets ovf_o, leaves tos_o unchanged and loads target_i. ovf_o then stays high until reset.
- R9: A taken return while tos_o = 0 sets unf_o, leaves tos_o unchanged and advances pc_o by one. unf_o then stays high until reset.
- R10: Nested calls return in last-in first-out order, each return resuming one past its own call site.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Advance one instruction |
| cmd_i | input | 2 | Flow command: 0 none, 1 jump, 2 call, 3 return |
| cond_i | input | 3 | Condition selector |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| target_i | input | 10 | Jump or call target address |
| pc_o | output | 10 | Program counter |
| tos_o | output | 5 | Number of occupied stack entries |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
Every result is due exactly one clock edge after the step that causes it. The program counter, the stack pointer, the stack entry and the error flags are all updated at that single edge, with no further pipeline stage. The bench applies inputs on the falling edge, pulses step_i across one rising edge, and compares all four outputs on the next falling edge against a reference model advanced by the same step. Steps with step_i low are checked the same way and must show no change.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  parameter int PC_W = 10;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_JUMP = 2'd1,
    CMD_CALL = 2'd2,
    CMD_RET  = 2'd3
  } flow_cmd_e;

  typedef enum logic [2:0] {
    SEL_ALWAYS = 3'd0,
    SEL_C      = 3'd1,
    SEL_NC     = 3'd2,
    SEL_Z      = 3'd3,
    SEL_NZ     = 3'd4
  } cond_sel_e;
endpackage

// File: rtl/cond_eval.sv
module cond_eval (
  input  logic [2:0] sel_i,
  input  logic       c_i,
  input  logic       z_i,
  output logic       taken_o
);
  import pcs_pkg::*;

  always_comb begin
    unique case (sel_i)
      SEL_ALWAYS: taken_o = 1'b1;
      SEL_C:      taken_o = c_i;
      SEL_NC:     taken_o = ~c_i;
      SEL_Z:      taken_o = z_i;
      SEL_NZ:     taken_o = ~z_i;
      default:    taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 30,
  parameter int DW    = 10,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] count_q;
  logic [CW-1:0] top_idx;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign top_idx = empty_o ? '0 : count_q - 1'b1;
  assign rdata_o = mem_q[top_idx];
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (push_i && !full_o) begin
      count_q <= count_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      count_q <= count_q - 1'b1;
    end
  end

  // storage needs no reset: entries above the pointer are never read
  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[count_q] <= wdata_i;
  end

  p_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  p_push_grow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> count_q == $past(count_q) + 1'b1);

  p_push_lifo_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> rdata_o == $past(wdata_i));

  p_full_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> count_q == $past(count_q));
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit #(
  parameter int PC_W  = pcs_pkg::PC_W,
  parameter int DEPTH = 30,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic [1:0]      cmd_i,
  input  logic [2:0]      cond_i,
  input  logic            flag_c_i,
  input  logic            flag_z_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o,
  output logic [CW-1:0]   tos_o,
  output logic            ovf_o,
  output logic            unf_o
);
  import pcs_pkg::*;

  logic [PC_W-1:0] pc_q, pc_d, pc_inc, ret_addr;
  logic            taken, push, pop, full, empty;
  logic            ovf_q, unf_q, ovf_set, unf_set;
  flow_cmd_e       cmd;

  assign cmd    = flow_cmd_e'(cmd_i);
  assign pc_inc = pc_q + 1'b1;

  cond_eval u_cond (
    .sel_i  (cond_i),
    .c_i    (flag_c_i),
    .z_i    (flag_z_i),
    .taken_o(taken)
  );

  ret_stack #(.DEPTH(DEPTH), .DW(PC_W)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .wdata_i(pc_q),
    .rdata_o(ret_addr),
    .count_o(tos_o),
    .full_o (full),
    .empty_o(empty)
  );

  always_comb begin
    pc_d    = pc_inc;
    push    = 1'b0;
    pop     = 1'b0;
    ovf_set = 1'b0;
    unf_set = 1'b0;
    unique case (cmd)
      CMD_JUMP: if (taken) pc_d = target_i;
      CMD_CALL: if (taken) begin
        pc_d    = target_i;
        push    = step_i && !full;
        ovf_set = full;
      end
      CMD_RET: if (taken) begin
        if (!empty) pc_d = ret_addr + 1'b1;
        pop     = step_i && !empty;
        unf_set = empty;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (step_i) begin
      pc_q  <= pc_d;
      ovf_q <= ovf_q | ovf_set;
      unf_q <= unf_q | unf_set;
    end
  end

  assign pc_o  = pc_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o) && $stable(tos_o) && $stable(ovf_o) && $stable(unf_o));

  p_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cmd_i == 2'd0) |=> pc_o == $past(pc_o) + 1'b1);

  p_fallthru_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cmd_i != 2'd0 && !taken) |=> pc_o == $past(pc_o) + 1'b1 && $stable(tos_o));

  p_call_tgt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cmd_i == 2'd2 && taken) |=> pc_o == $past(target_i));

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  p_unf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);
endmodule

// File: tb/tb_pc_stack_unit.sv
module tb_pc_stack_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       step_i = 1'b0;
  logic [1:0] cmd_i = '0;
  logic [2:0] cond_i = '0;
  logic       flag_c_i = 1'b0, flag_z_i = 1'b0;
  logic [9:0] target_i = '0;
  logic [9:0] pc_o;
  logic [4:0] tos_o;
  logic       ovf_o, unf_o;

  int errs = 0, checks = 0;
  bit done = 0;

  logic [9:0] m_pc;
  logic [9:0] m_stk [32];
  int         m_tos;
  logic       m_ovf, m_unf;

  always #5 clk_i = ~clk_i;

  pc_stack_unit dut (.*);

  function automatic bit cond_ok(logic [2:0] s, logic c, logic z);
    case (s)
      3'd0: return 1'b1;
      3'd1: return c;
      3'd2: return !c;
      3'd3: return z;
      3'd4: return !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag);
    checks++;
    if (pc_o !== m_pc || tos_o !== 5'(m_tos) || ovf_o !== m_ovf || unf_o !== m_unf) begin
      errs++;
      $display("FAIL %s: pc=%h tos=%0d ovf=%b unf=%b expected pc=%h tos=%0d ovf=%b unf=%b",
               tag, pc_o, tos_o, ovf_o, unf_o, m_pc, m_tos, m_ovf, m_unf);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; step_i = 1'b0;
    m_pc = '0; m_tos = 0; m_ovf = 0; m_unf = 0;
    @(negedge clk_i);
    chk("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release");
  endtask

  // apply one step (or a held cycle when en is 0) and compare one edge later
  task automatic do_step(bit en, logic [1:0] cmd, logic [2:0] cs, logic c, logic z,
                         logic [9:0] tgt, string tag);
    bit t;
    step_i = en; cmd_i = cmd; cond_i = cs; flag_c_i = c; flag_z_i = z; target_i = tgt;
    t = cond_ok(cs, c, z);
    if (en) begin
      case (cmd)
        2'd0: m_pc = m_pc + 1'b1;
        2'd1: m_pc = t ? tgt : m_pc + 1'b1;
        2'd2: if (t) begin
          if (m_tos == 30) m_ovf = 1;
          else begin m_stk[m_tos] = m_pc; m_tos++; end
          m_pc = tgt;
        end else m_pc = m_pc + 1'b1;
        default: if (t && m_tos > 0) begin
          m_tos--; m_pc = m_stk[m_tos] + 1'b1;
        end else begin
          if (t) m_unf = 1;
          m_pc = m_pc + 1'b1;
        end
      endcase
    end
    @(posedge clk_i);
    @(negedge clk_i);
    step_i = 1'b0;
    chk(tag);
  endtask

  task automatic t_seq_hold();
    do_reset();
    do_step(1, 2'd0, 3'd0, 0, 0, 10'h155, "R3 sequential");
    do_step(1, 2'd0, 3'd5, 1, 1, 10'h2AA, "R3 sequential");
    do_step(0, 2'd1, 3'd0, 0, 0, 10'h100, "R2 jump held");
    do_step(0, 2'd2, 3'd0, 0, 0, 10'h100, "R2 call held");
    do_step(1, 2'd1, 3'd0, 0, 0, 10'h3FE, "R4 jump always");
    do_step(1, 2'd0, 3'd0, 0, 0, 10'h000, "R3 to 3FF");
    do_step(1, 2'd0, 3'd0, 0, 0, 10'h000, "R3 wrap");
  endtask

  task automatic t_cond_jump();
    do_reset();
    for (int s = 0; s < 8; s++)
      for (int f = 0; f < 4; f++)
        do_step(1, 2'd1, 3'(s), f[0], f[1], 10'(40 * s + 7 * f + 3),
                cond_ok(3'(s), f[0], f[1]) ? "R4 jump taken" : "R5 jump not taken");
  endtask

  task automatic t_call_ret();
    do_reset();
    do_step(1, 2'd1, 3'd0, 0, 0, 10'h050, "R4 setup");
    do_step(1, 2'd2, 3'd2, 1, 0, 10'h200, "R5 call NC false");
    do_step(1, 2'd2, 3'd1, 1, 0, 10'h200, "R6 call C true");
    do_step(1, 2'd0, 3'd0, 0, 0, 10'h000, "R3 in sub");
    do_step(1, 2'd3, 3'd3, 0, 0, 10'h000, "R5 ret Z false");
    do_step(0, 2'd3, 3'd0, 0, 0, 10'h000, "R2 ret held");
    do_step(1, 2'd3, 3'd4, 0, 0, 10'h000, "R7 ret NZ true");
    do_step(1, 2'd2, 3'd0, 0, 0, 10'h300, "R10 nest outer");
    do_step(1, 2'd2, 3'd3, 0, 1, 10'h3F0, "R10 nest inner");
    do_step(1, 2'd3, 3'd0, 0, 0, 10'h000, "R10 inner back");
    do_step(1, 2'd3, 3'd0, 0, 0, 10'h000, "R10 outer back");
  endtask

  task automatic t_limits();
    do_reset();
    do_step(1, 2'd3, 3'd0, 0, 0, 10'h000, "R9 underflow");
    do_step(1, 2'd0, 3'd0, 0, 0, 10'h000, "R9 sticky");
    do_reset();
    for (int i = 0; i < 30; i++)
      do_step(1, 2'd2, 3'd0, 0, 0, 10'(i * 33 + 5), "R6 fill");
    do_step(1, 2'd2, 3'd0, 0, 0, 10'h3C0, "R8 overflow");
    do_step(1, 2'd2, 3'd1, 0, 0, 10'h111, "R5 full call false");
    for (int i = 0; i < 30; i++)
      do_step(1, 2'd3, 3'd0, 0, 0, 10'h000, "R10 drain");
    do_step(1, 2'd3, 3'd0, 0, 0, 10'h000, "R9 empty return");
    do_step(1, 2'd0, 3'd0, 0, 0, 10'h000, "R8 R9 sticky both");
  endtask

  initial begin
    t_seq_hold();
    t_cond_jump();
    t_call_ret();
    t_limits();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule